// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Controller

This block gathers single-cycle event pulses from an Ethernet MAC's DMA engines and link interface, holds each one in a sticky status bit, and raises one interrupt line when any held event is also enabled. Software reads the status word, handles the events it finds, and acknowledges them by writing the same value back. A write of a one clears that bit. A write of a zero leaves it as it is.

Access is through a small 32-bit register port with an 8-bit byte offset, a write strobe and a read-data bus. Reads are combinational from the offset. The status word is at offset 0x08 and the enable word at offset 0x0C. All other offsets read as zero and ignore writes. A driver typically enables only the two "done" interrupts in normal operation. It writes zero to the enable word to mask everything, and it writes 0x1FFFFFF to the status word to clear every pending event.

Top module: `eirq_ctrl_top`

## Requirements
- R1: After reset the status word, the enable word and `irq` are all zero.
- R2: A pulse on `tx_evt[i]` (i = 0..5: done, DMA stopped, buffer unavailable, timeout, underflow, early) sets status bit i at the next clock edge.
- R3: A pulse on `rx_evt[i]` (i = 0..5: done, buffer unavailable, DMA stopped, timeout, overflow, early) sets status bit 8+i, and a pulse on `link_evt` sets status bit 16.
- R4: Status bits latch whatever the enable word holds, and a status bit never sets without its event.
- R5: A write to offset 0x08 clears every status bit whose bit in bits 24..0 of the written data is one and leaves the others unchanged. Writing 0x1FFFFFF clears all of them.
- R6: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x0C loads the enable word. Only bits 0..5, 8..13 and 16 are stored, and the enable word reads back at 0x0C.
- R8: `irq` is the OR of (status AND enable), registered once. It therefore follows the status and enable words one cycle later.
- R9: Bits outside 0..5, 8..13 and 16 of the status word read as zero. Offsets other than 0x08 and 0x0C read zero, and writes to them change neither word.
- R10: Writing zero to the enable word drops `irq` one cycle after the write, even while status bits remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_evt | input | 6 | Transmit-path event pulses |
| rx_evt | input | 6 | Receive-path event pulses |
| link_evt | input | 1 | Link-status change pulse |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A status bit stuck at zero, lost to a clearing write, or set without its event shows on `bus_rdata` at offset 0x08 in the cycle after the edge that should have changed it. A wrong enable bit or a missing output register shows on `irq` exactly one edge after the status or enable change. The vector table covers bit positions, partial clears and the event-beats-clear collision cycle. Directed tests look at latency by sampling `irq` both before and after the extra edge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int TX_N      = 6;
    localparam int RX_N      = 6;
    localparam int TX_BASE   = 0;
    localparam int RX_BASE   = 8;
    localparam int LINK_BIT  = 16;
    localparam int CLR_W     = 25;
    localparam logic [ADDR_W-1:0] STS_OFS = 8'h08;
    localparam logic [ADDR_W-1:0] ENA_OFS = 8'h0C;

    function automatic logic [REG_W-1:0] valid_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < TX_N; i++) m[TX_BASE + i] = 1'b1;
        for (int i = 0; i < RX_N; i++) m[RX_BASE + i] = 1'b1;
        m[LINK_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] VMASK = valid_mask();
    localparam logic [REG_W-1:0] CLR_FIELD = REG_W'((64'd1 << CLR_W) - 64'd1);

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } sts_state_t;

    typedef struct packed {
        logic [REG_W-1:0] ena;
        logic             irq;
    } irq_state_t;
endpackage

// File: rtl/eirq_event_map.sv
module eirq_event_map
    import eirq_pkg::*;
(
    input  logic [TX_N-1:0]  tx_evt,
    input  logic [RX_N-1:0]  rx_evt,
    input  logic             link_evt,
    output logic [REG_W-1:0] evt_vec
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b >= TX_BASE && b < TX_BASE + TX_N) begin : g_tx
            assign evt_vec[b] = tx_evt[b - TX_BASE];
        end else if (b >= RX_BASE && b < RX_BASE + RX_N) begin : g_rx
            assign evt_vec[b] = rx_evt[b - RX_BASE];
        end else if (b == LINK_BIT) begin : g_link
            assign evt_vec[b] = link_evt;
        end else begin : g_rsvd
            assign evt_vec[b] = 1'b0;
        end
    end
endmodule

// File: rtl/eirq_status_reg.sv
module eirq_status_reg
    import eirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_vec,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_val,
    output logic [REG_W-1:0] sts_q
);
    sts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.bits = st_d.bits & ~(clr_val & CLR_FIELD);
        st_d.bits = (st_d.bits | evt_vec) & VMASK;   // new event beats clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_q = st_q.bits;

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((sts_q & $past(evt_vec & VMASK)) == $past(evt_vec & VMASK))); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((sts_q & $past(clr_val & CLR_FIELD & ~evt_vec)) == '0)); // R5
    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_vec)) == '0)); // R4
endmodule

// File: rtl/eirq_mask_irq.sv
module eirq_mask_irq
    import eirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] ena_q,
    output logic             irq_q
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(sts & st_q.ena);
        if (ena_wr) st_d.ena = wdata & VMASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_q = st_q.ena;
    assign irq_q = st_q.irq;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == $past(|(sts & ena_q)))); // R8
    AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr |=> (ena_q == $past(wdata & VMASK))); // R7
endmodule

// File: rtl/eirq_ctrl_top.sv
module eirq_ctrl_top
    import eirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [TX_N-1:0]   tx_evt,
    input  logic [RX_N-1:0]   rx_evt,
    input  logic              link_evt,
    output logic              irq
);
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] ena_q;
    logic             sel_sts, sel_ena;

    assign sel_sts = (bus_addr == STS_OFS);
    assign sel_ena = (bus_addr == ENA_OFS);

    eirq_event_map i_map (
        .tx_evt  (tx_evt),
        .rx_evt  (rx_evt),
        .link_evt(link_evt),
        .evt_vec (evt_vec)
    );

    eirq_status_reg i_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_vec(evt_vec),
        .clr_en (bus_wr && sel_sts),
        .clr_val(bus_wdata),
        .sts_q  (sts_q)
    );

    eirq_mask_irq i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ena_wr(bus_wr && sel_ena),
        .wdata (bus_wdata),
        .sts   (sts_q),
        .ena_q (ena_q),
        .irq_q (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_sts)      bus_rdata = sts_q;
        else if (sel_ena) bus_rdata = ena_q;
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~VMASK) == '0)); // R9
    AST_MASK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |=> !irq); // R10
endmodule

// File: tb/test_eirq_ctrl_top.sv
module test_eirq_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h08;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  tx_evt = '0;
    logic [5:0]  rx_evt = '0;
    logic        link_evt = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    eirq_ctrl_top i_eirq_ctrl_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .link_evt(link_evt), .irq(irq)
    );

    // {ev[12:0] = {link, rx[5:0], tx[5:0]}, clear data (0 = no write), expected status}
    localparam int NV = 10;
    localparam logic [76:0] VEC [NV] = '{
        {13'h0001, 32'h0000_0000, 32'h0000_0001},  // R2 tx done
        {13'h003F, 32'h0000_0000, 32'h0000_003F},  // R2 all tx
        {13'h0FC0, 32'h0000_0000, 32'h0000_3F3F},  // R3 all rx
        {13'h1000, 32'h0000_0000, 32'h0001_3F3F},  // R3 link
        {13'h0000, 32'h0000_0003, 32'h0001_3F3C},  // R5 partial clear
        {13'h0001, 32'h0000_0001, 32'h0001_3F3D},  // R6 event wins
        {13'h0000, 32'h01FF_FFFF, 32'h0000_0000},  // R5 clear all
        {13'h0080, 32'h0000_0000, 32'h0000_0200},  // R3 rx bit 9
        {13'h1000, 32'hFFFF_FFFF, 32'h0001_0000},  // R6 link beats clear
        {13'h0000, 32'h0001_0000, 32'h0000_0000}   // R5 clear link
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h08, r); check("R1 status", r, 32'h0);
        rd(8'h0C, r); check("R1 enable", r, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            bus_addr = 8'h08;
            {link_evt, rx_evt, tx_evt} = VEC[k][76:64];
            bus_wdata = VEC[k][63:32];
            bus_wr = (VEC[k][63:32] != 0);
            @(negedge clk);
            {link_evt, rx_evt, tx_evt} = '0;
            bus_wr = 1'b0;
            #1 check($sformatf("R2/R3/R5/R6 vec%0d", k), bus_rdata, VEC[k][31:0]);
            check("R4 irq masked", {31'd0, irq}, 32'h0);
        end

        // R7 enable reserved bits
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, r); check("R7 enable readback", r, 32'h0001_3F3F);
        wr(8'h0C, 32'h0);
        // R9 unmapped offset
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, r); check("R9 unmapped read", r, 32'h0);
        rd(8'h0C, r); check("R9 enable untouched", r, 32'h0);

        // R4 event latches with enable 0
        @(negedge clk); rx_evt = 6'b000001;
        @(negedge clk); rx_evt = '0;
        #1 check("R4 irq off", {31'd0, irq}, 32'h0);
        rd(8'h08, r); check("R4 latched", r, 32'h0000_0100);

        // R8 latency: enable written at edge e, irq at e+1
        @(negedge clk); bus_addr = 8'h0C; bus_wdata = 32'h0000_0101; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        #1 check("R8 irq not yet", {31'd0, irq}, 32'h0);
        @(negedge clk);
        #1 check("R8 irq set", {31'd0, irq}, 32'h1);

        // R10 mask all
        @(negedge clk); bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        #1 check("R10 irq still set", {31'd0, irq}, 32'h1);
        @(negedge clk);
        #1 check("R10 irq dropped", {31'd0, irq}, 32'h0);
        rd(8'h08, r); check("R10 status kept", r, 32'h0000_0100);

        // R5 acknowledge by write-back of read value
        wr(8'h08, r);
        rd(8'h08, r); check("R5 write-back ack", r, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule